// File: doc/BRIEF.md
# DMA Channel Select and Priority Register Bank

This block is the per-channel control storage of a multi-channel DMA controller. For each implemented channel it keeps two bits. One selects the alternate data structure in place of the primary one. The other raises the channel from normal to high priority. It also keeps one sticky error interrupt flag. Software reaches everything through a simple 32-bit register bus made of an address, a write enable, write data and read data. The current bits drive the channel arbiter and the interrupt line directly.

No control bit is written directly. Each per-channel bit has two aliases: a write-one-to-set word and a write-one-to-clear word. Zeros written to either alias change nothing, so different pieces of software can change single channels without a read-modify-write. Hardware raises the error flag with a one-cycle pulse, and software lowers it by writing one to bit 0 of the error word.

The word map, by byte address, is:

| Address | Word | Behaviour |
|---|---|---|
| 0x00 | alternate-select set | read returns the select bits |
| 0x04 | alternate-select clear | write-only |
| 0x08 | priority set | read returns the priority bits |
| 0x0C | priority clear | write-only |
| 0x10 | error flag | flag in bit 0 |

The channel count is the parameter `NUM_CH`, from 1 to 32. Bit n of a word belongs to channel n.

Top module: `dma_chan_ctrl_bank`

## Requirements
- R1: After a synchronous active-high reset, every alternate-select bit, every priority bit and the error flag are 0, and so are `alt_sel`, `hi_prio` and `err_irq`.
- R2: A write to 0x00 sets the alternate-select bit of each channel whose data bit is 1 and leaves the other channels unchanged. The new value shows on `alt_sel` and on a read of 0x00 from the clock edge after the write.
- R3: A write to 0x04 clears the alternate-select bit of each channel whose data bit is 1. Zero bits leave their channel unchanged.
- R4: A write to 0x08 makes each channel whose data bit is 1 high priority and leaves the others unchanged. A read of 0x08 returns 1 for high-priority channels and 0 for normal-priority channels, and `hi_prio` carries the same bits.
- R5: A write to 0x0C returns each channel whose data bit is 1 to normal priority. Zero bits leave their channel unchanged.
- R6: Reads of 0x04 and 0x0C always return 0.
- R7: Data bits at positions `NUM_CH` and above are ignored on every write, and those positions always read 0.
- R8: A one-cycle `err_pulse` sets the error flag at the next clock edge. The flag then stays set, shows on `err_irq`, and reads as bit 0 of 0x10. Bits 31 to 1 of 0x10 read 0.
- R9: A write to 0x10 with data bit 0 at 1 clears the error flag. A write to 0x10 with bit 0 at 0 leaves it unchanged.
- R10: When `err_pulse` and a clearing write to 0x10 happen in the same cycle, the error flag stays set.
- R11: A cycle with `bus_we` low changes no state. Writes to the unmapped addresses 0x14, 0x18 and 0x1C change no state, and reads of those addresses return 0.
- R12: `bus_rdata` is combinational from `bus_addr` and the current state, with no read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the word |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| err_pulse | input | 1 | Hardware error event, one cycle |
| alt_sel | output | NUM_CH | Alternate-structure select per channel |
| hi_prio | output | NUM_CH | High-priority flag per channel |
| err_irq | output | 1 | Error interrupt request |

## Verification
Every write and every error pulse changes state at the first rising edge after it is presented. The bench therefore drives stimulus on a falling edge, removes it on the next falling edge, and only then checks the outputs and the readback. Reads have no latency. The bench sets the address on a falling edge and samples `bus_rdata` one nanosecond later, long before the next rising edge. In the same-cycle race between a pulse and a clear, both stimuli cover one single rising edge, and the flag is checked at the falling edge after it.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 5;
    localparam int unsigned WORD_LSB = 2;
    localparam int unsigned IDX_W   = ADDR_W - WORD_LSB;

    typedef enum logic [IDX_W-1:0] {
        W_ALT_SET = 3'd0,
        W_ALT_CLR = 3'd1,
        W_PRI_SET = 3'd2,
        W_PRI_CLR = 3'd3,
        W_ERR     = 3'd4,
        W_NONE5   = 3'd5,
        W_NONE6   = 3'd6,
        W_NONE7   = 3'd7
    } word_e;

    typedef struct packed {
        logic alt_set;
        logic alt_clr;
        logic pri_set;
        logic pri_clr;
        logic err_clr;
    } wr_strobe_t;
endpackage

// File: rtl/dcb_decode.sv
module dcb_decode
    import dcb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              wbit0,
    output word_e             word,
    output wr_strobe_t        strobe
);
    always_comb begin
        word   = word_e'(addr[ADDR_W-1:WORD_LSB]);
        strobe = '0;
        if (we) begin
            unique case (word)
                W_ALT_SET: strobe.alt_set = 1'b1;
                W_ALT_CLR: strobe.alt_clr = 1'b1;
                W_PRI_SET: strobe.pri_set = 1'b1;
                W_PRI_CLR: strobe.pri_clr = 1'b1;
                W_ERR:     strobe.err_clr = wbit0;
                default:   strobe = '0;
            endcase
        end
    end

    always_comb begin
        a_r11_one_strobe: assert ($onehot0(strobe));
    end
endmodule

// File: rtl/dcb_setclr_bits.sv
module dcb_setclr_bits #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (set_we)
            q <= q | mask;
        else if (clr_we)
            q <= q & ~mask;
    end

    // R2 and R4: masked channels become 1 after a set write
    a_r2_set_applies: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((q & $past(mask)) == $past(mask)));
    // R3 and R5: masked channels become 0 after a clear write
    a_r3_clear_applies: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((q & $past(mask)) == '0));
    // R2, R3: channels with a zero mask bit keep their value
    a_r3_zeros_hold: assert property (@(posedge clk) disable iff (rst)
        (set_we || clr_we) |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(q));
endmodule

// File: rtl/dcb_err_flag.sv
module dcb_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic hw_err,
    input  logic sw_clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (hw_err)
            flag <= 1'b1;
        else if (sw_clr)
            flag <= 1'b0;
    end

    a_r8_pulse_sets: assert property (@(posedge clk) disable iff (rst)
        hw_err |=> flag);
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !sw_clr) |=> flag);
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && !hw_err) |=> !flag);
    a_r10_race_keeps: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && hw_err) |=> flag);
endmodule

// File: rtl/dma_chan_ctrl_bank.sv
module dma_chan_ctrl_bank
    import dcb_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              err_pulse,
    output logic [NUM_CH-1:0] alt_sel,
    output logic [NUM_CH-1:0] hi_prio,
    output logic              err_irq
);
    localparam int unsigned CH_MSB = NUM_CH - 1;

    word_e      word;
    wr_strobe_t strobe;
    logic [NUM_CH-1:0] ch_mask;

    assign ch_mask = bus_wdata[CH_MSB:0];

    dcb_decode u_decode (
        .addr   (bus_addr),
        .we     (bus_we),
        .wbit0  (bus_wdata[0]),
        .word   (word),
        .strobe (strobe)
    );

    dcb_setclr_bits #(.WIDTH(NUM_CH)) u_alt (
        .clk    (clk),
        .rst    (rst),
        .set_we (strobe.alt_set),
        .clr_we (strobe.alt_clr),
        .mask   (ch_mask),
        .q      (alt_sel)
    );

    dcb_setclr_bits #(.WIDTH(NUM_CH)) u_pri (
        .clk    (clk),
        .rst    (rst),
        .set_we (strobe.pri_set),
        .clr_we (strobe.pri_clr),
        .mask   (ch_mask),
        .q      (hi_prio)
    );

    dcb_err_flag u_err (
        .clk    (clk),
        .rst    (rst),
        .hw_err (err_pulse),
        .sw_clr (strobe.err_clr),
        .flag   (err_irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (word)
            W_ALT_SET: bus_rdata[CH_MSB:0] = alt_sel;
            W_PRI_SET: bus_rdata[CH_MSB:0] = hi_prio;
            W_ERR:     bus_rdata[0]        = err_irq;
            default:   bus_rdata = '0;
        endcase
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (alt_sel == '0 && hi_prio == '0 && !err_irq));
    a_r6_clr_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (word == W_ALT_CLR || word == W_PRI_CLR) |-> bus_rdata == '0);
    a_r8_err_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (word == W_ERR) |-> bus_rdata[31:1] == '0);
    a_r11_quiet_stable: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && !err_pulse) |=> ($stable(alt_sel) && $stable(hi_prio) && $stable(err_irq)));
endmodule

// File: tb/dma_chan_ctrl_bank_tb.sv
module dma_chan_ctrl_bank_tb;
    localparam int unsigned NCH = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [4:0]      bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            err_pulse = 1'b0;
    logic [NCH-1:0]  alt_sel;
    logic [NCH-1:0]  hi_prio;
    logic            err_irq;

    int checks = 0;
    int errors = 0;
    logic [NCH-1:0] exp_alt = '0;
    logic [NCH-1:0] exp_pri = '0;
    logic           exp_err = 1'b0;

    always #4 clk = ~clk;

    dma_chan_ctrl_bank #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_pulse(err_pulse),
        .alt_sel(alt_sel), .hi_prio(hi_prio), .err_irq(err_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic check_state(input string req);
        check({req, " alt_sel"}, 32'(alt_sel), 32'(exp_alt));
        check({req, " hi_prio"}, 32'(hi_prio), 32'(exp_pri));
        check({req, " err_irq"}, 32'(err_irq), 32'(exp_err));
    endtask

    task automatic t_reset();
        check_state("R1");
        rd_check("R1 read alt", 5'h00, 32'h0);
        rd_check("R1 read pri", 5'h08, 32'h0);
        rd_check("R1 read err", 5'h10, 32'h0);
    endtask

    task automatic t_alt();
        wr(5'h00, 32'h0000_0005); exp_alt = 8'h05;
        check_state("R2 set");
        rd_check("R2 readback", 5'h00, 32'h05);
        wr(5'h00, 32'h0000_0030); exp_alt = 8'h35;
        check_state("R2 accumulate");
        wr(5'h04, 32'h0000_0011); exp_alt = 8'h24;
        check_state("R3 clear");
        wr(5'h04, 32'h0000_0000);
        check_state("R3 zero write");
        rd_check("R3 readback", 5'h00, 32'h24);
    endtask

    task automatic t_pri();
        wr(5'h08, 32'h0000_00C3); exp_pri = 8'hC3;
        check_state("R4 set");
        rd_check("R4 readback", 5'h08, 32'hC3);
        wr(5'h0C, 32'h0000_0081); exp_pri = 8'h42;
        check_state("R5 clear");
        wr(5'h0C, 32'h0000_0000);
        check_state("R5 zero write");
        rd_check("R5 readback", 5'h08, 32'h42);
    endtask

    task automatic t_clr_reads();
        rd_check("R6 alt clear word", 5'h04, 32'h0);
        rd_check("R6 pri clear word", 5'h0C, 32'h0);
    endtask

    task automatic t_upper();
        wr(5'h00, 32'hFFFF_FF00);
        wr(5'h08, 32'hAAAA_AA00);
        check_state("R7 upper set");
        wr(5'h00, 32'hFFFF_FFFF); exp_alt = 8'hFF;
        rd_check("R7 alt read", 5'h00, 32'h0000_00FF);
        wr(5'h04, 32'hFFFF_FF0F); exp_alt = 8'hF0;
        check_state("R7 upper clear");
        rd_check("R7 alt after clear", 5'h00, 32'h0000_00F0);
    endtask

    task automatic t_err();
        @(negedge clk); err_pulse = 1'b1;
        @(negedge clk); err_pulse = 1'b0; exp_err = 1'b1;
        check_state("R8 pulse");
        repeat (3) @(negedge clk);
        check_state("R8 sticky");
        rd_check("R8 read", 5'h10, 32'h1);
        wr(5'h10, 32'hFFFF_FFFE);
        check_state("R9 zero bit0");
        wr(5'h10, 32'h0000_0001); exp_err = 1'b0;
        check_state("R9 clear");
        rd_check("R9 read", 5'h10, 32'h0);
    endtask

    task automatic t_err_race();
        @(negedge clk);
        bus_addr = 5'h10; bus_wdata = 32'h1; bus_we = 1'b1; err_pulse = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; err_pulse = 1'b0; bus_wdata = '0; exp_err = 1'b1;
        check_state("R10 race");
        wr(5'h10, 32'h1); exp_err = 1'b0;
        check_state("R10 later clear");
    endtask

    task automatic t_quiet();
        @(negedge clk);
        bus_addr = 5'h04; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b0;
        @(negedge clk);
        bus_addr = 5'h08;
        @(negedge clk);
        bus_wdata = '0;
        check_state("R11 we low");
        for (int a = 5; a < 8; a++) begin
            wr(5'(a * 4), 32'hFFFF_FFFF);
            check_state("R11 unmapped write");
            rd_check("R11 unmapped read", 5'(a * 4), 32'h0);
        end
    endtask

    task automatic t_comb_read();
        @(negedge clk);
        bus_addr = 5'h00; #1;
        check("R12 alt", bus_rdata, 32'(exp_alt));
        bus_addr = 5'h08; #1;
        check("R12 pri", bus_rdata, 32'(exp_pri));
        bus_addr = 5'h10; #1;
        check("R12 err", bus_rdata, 32'(exp_err));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_alt();
        t_pri();
        t_clr_reads();
        t_upper();
        t_err();
        t_err_race();
        t_quiet();
        t_comb_read();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_alt = '0; exp_pri = '0; exp_err = 1'b0;
        check_state("R1 second reset");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule